// File: doc/BRIEF.md
# Parallel-Load Shift Register with JK Serial Entry

This block is a small register, four stages wide by default, with two modes of operation. A mode input chooses the mode on every rising clock edge. In shift mode, each bit moves one stage toward the last stage. Stage 0 takes a new bit, which a J input and an active-low K input produce together. In load mode, the parallel data inputs are written into all stages at once. The register then acts as a set of plain clocked D flip-flops.

An active-low reset clears every stage at once. It acts whatever the clock, the mode and the data inputs are doing. Besides the stage values, the block drives the complement of the last stage. To get a left shift, the surrounding logic feeds each stage output back to the data input one position lower and holds the block in load mode. The block has no internal mode for this.

The two modes are the enumerated operations `OP_SHIFT` and `OP_LOAD`. The block decodes them from `shift_nload` on every cycle and has no other states. The possible transitions are: load to load, load to shift, shift to shift, and shift to load, each taken at a rising edge. Any operation goes to the cleared condition when `rst_n` falls, whether or not a clock edge occurs.

Top module: `pls_shift_reg`

## Requirements
- R1: When `shift_nload` is 1 at a rising edge, each stage n (n = 1..W-1) takes the value that stage n-1 held before that edge.
- R2: When `shift_nload` is 0 at a rising edge, `q` takes the value of `par_d`, with bit n going to stage n.
- R3: On a shift, `j`=1 with `kn`=1 sets stage 0 to 1, and `j`=0 with `kn`=0 clears it to 0. Tying the two inputs together therefore gives a D-type serial input.
- R4: On a shift, `j`=0 with `kn`=1 keeps the old value of stage 0, and `j`=1 with `kn`=0 inverts it.
- R5: A falling `rst_n` clears `q` to all zeros at once, without a clock edge.
- R6: While `rst_n` is low, rising clock edges leave `q` at zero, whatever the mode and data inputs are.
- R7: `q_last_n` always equals the inverse of the last stage, `q[W-1]`, and so it is 1 during reset.
- R8: At the first rising edge after `rst_n` returns high, the register carries out the selected operation normally.
- R9: Feeding `q[n]` into `par_d[n-1]` while in load mode moves the contents one stage toward stage 0. The top data bit supplied with it enters the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| shift_nload | input | 1 | 1 = shift toward last stage, 0 = parallel load |
| j | input | 1 | Serial entry J input |
| kn | input | 1 | Serial entry K input, active low |
| par_d | input | W | Parallel data inputs |
| q | output | W | Stage outputs, bit 0 = first stage |
| q_last_n | output | 1 | Complement of the last stage |

## Verification
The embedded assertions check the following on every clock edge:
- the load capture;
- the move of each bit by one stage during a shift;
- all four J/K-bar results at stage 0;
- zero contents while reset is held.

Some behaviour only the bench's scenarios can show. These are the clearing of the register between edges, before any clock arrives, and a correct first operation right after reset release. They also include left shifting through external feedback and long random mixes of the two modes. The bench checks each of these against an independent queue-based model on every clock.

// File: rtl/pls_pkg.sv
package pls_pkg;
    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_SHIFT = 1'b1
    } pls_op_e;
endpackage

// File: rtl/pls_entry.sv
// First-stage serial entry: J / active-low K decode for a shift cycle.
module pls_entry (
    input  logic j,
    input  logic kn,
    input  logic cur_bit,
    output logic nxt_bit
);
    always_comb begin
        unique case ({j, kn})
            2'b00: nxt_bit = 1'b0;       // clear
            2'b11: nxt_bit = 1'b1;       // set
            2'b01: nxt_bit = cur_bit;    // hold
            2'b10: nxt_bit = ~cur_bit;   // toggle
            default: nxt_bit = cur_bit;
        endcase
    end
endmodule

// File: rtl/pls_next.sv
// Next-state selector: chooses shifted or loaded contents per operation.
module pls_next #(
    parameter int W = 4
) (
    input  pls_pkg::pls_op_e op,
    input  logic [W-2:0]     low_bits,
    input  logic             entry_bit,
    input  logic [W-1:0]     par_d,
    output logic [W-1:0]     nxt
);
    logic [W-1:0] shifted;

    assign shifted[0] = entry_bit;
    for (genvar g = 1; g < W; g++) begin : g_stage
        assign shifted[g] = low_bits[g-1];
    end

    always_comb begin
        unique case (op)
            pls_pkg::OP_SHIFT: nxt = shifted;
            pls_pkg::OP_LOAD:  nxt = par_d;
            default:           nxt = par_d;
        endcase
    end
endmodule

// File: rtl/pls_shift_reg.sv
module pls_shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_nload,
    input  logic         j,
    input  logic         kn,
    input  logic [W-1:0] par_d,
    output logic [W-1:0] q,
    output logic         q_last_n
);
    import pls_pkg::*;

    localparam int LAST = W - 1;

    pls_op_e      op;
    logic         entry_bit;
    logic [W-1:0] nxt;
    logic [W-1:0] stage_q;

    assign op = shift_nload ? OP_SHIFT : OP_LOAD;

    pls_entry u_entry (
        .j       (j),
        .kn      (kn),
        .cur_bit (stage_q[0]),
        .nxt_bit (entry_bit)
    );

    pls_next #(.W(W)) u_next (
        .op        (op),
        .low_bits  (stage_q[W-2:0]),
        .entry_bit (entry_bit),
        .par_d     (par_d),
        .nxt       (nxt)
    );

    // State register with asynchronous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= nxt;
    end

    // Outputs
    always_comb begin
        q        = stage_q;
        q_last_n = ~stage_q[LAST];
    end

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_nload |=> q == $past(par_d)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_nload |=> q[W-1:1] == $past(q[W-2:0])); // R1
    AST_ENTRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_nload && j && kn) |=> q[0]); // R3
    AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_nload && !j && !kn) |=> !q[0]); // R3
    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_nload && !j && kn) |=> q[0] == $past(q[0])); // R4
    AST_ENTRY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_nload && j && !kn) |=> q[0] != $past(q[0])); // R4
    AST_RESET_HELD_ZERO: assert property (@(posedge clk)
        !rst_n |-> (q == '0 && q_last_n)); // R6
endmodule

// File: tb/pls_shift_reg_bench.sv
module pls_shift_reg_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_nload = 1'b0;
    logic         j = 1'b0;
    logic         kn = 1'b0;
    logic [W-1:0] par_d = '0;
    logic [W-1:0] q;
    logic         q_last_n;

    int n_checks = 0;
    int n_fail = 0;
    bit mdl[$];

    pls_shift_reg #(.W(W)) u_pls_shift_reg (
        .clk(clk), .rst_n(rst_n), .shift_nload(shift_nload), .j(j), .kn(kn),
        .par_d(par_d), .q(q), .q_last_n(q_last_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [W-1:0] mdl_vec();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = mdl[i];
        return v;
    endfunction

    task automatic mdl_clear();
        mdl.delete();
        for (int i = 0; i < W; i++) mdl.push_back(1'b0);
    endtask

    task automatic compare(input string tag);
        logic [W-1:0] e;
        e = mdl_vec();
        n_checks++;
        if (q !== e) begin
            n_fail++;
            $display("FAIL %s: q actual %b expected %b", tag, q, e);
        end
        n_checks++;
        if (q_last_n !== ~e[W-1]) begin
            n_fail++;
            $display("FAIL R7 (%s): q_last_n actual %b expected %b", tag, q_last_n, ~e[W-1]);
        end
    endtask

    task automatic do_cycle(input bit sh, input bit jj, input bit kk,
                            input logic [W-1:0] d, input string tag);
        bit nb;
        @(negedge clk);
        shift_nload = sh; j = jj; kn = kk; par_d = d;
        @(posedge clk);
        if (sh) begin
            case ({jj, kk})
                2'b00: nb = 1'b0;
                2'b11: nb = 1'b1;
                2'b01: nb = mdl[0];
                default: nb = !mdl[0];
            endcase
            mdl.push_front(nb);
            void'(mdl.pop_back());
        end else begin
            for (int i = 0; i < W; i++) mdl[i] = d[i];
        end
        #1 compare(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        mdl_clear();
        #1 compare("R5");
        shift_nload = 1'b0; par_d = '1;
        @(posedge clk);
        #1 compare("R6");
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        mdl_clear();
        #1 compare("R5 reset state");
        @(posedge clk);
        #1 compare("R6");
        #1 rst_n = 1'b1;

        do_cycle(0, 0, 0, 4'b1010, "R2 R8");
        do_cycle(0, 0, 0, 4'b0110, "R2");
        do_cycle(1, 1, 1, 4'b0000, "R1 R3 set");
        do_cycle(1, 0, 0, 4'b1111, "R1 R3 clear");
        do_cycle(1, 0, 1, 4'b0000, "R1 R4 hold");
        do_cycle(1, 1, 0, 4'b0000, "R1 R4 toggle");
        do_cycle(1, 1, 0, 4'b0000, "R1 R4 toggle");
        do_cycle(1, 0, 1, 4'b1111, "R1 R4 hold");
        // Left shift through external feedback
        do_cycle(0, 0, 0, 4'b1001, "R2");
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] cur;
            cur = mdl_vec();
            do_cycle(0, 0, 0, {k[0], cur[W-1:1]}, "R9 left shift");
        end
        do_reset();
        do_cycle(1, 1, 1, 4'b0000, "R8 R3");

        for (int n = 0; n < 2000; n++) begin
            int r;
            r = $urandom_range(0, 39);
            if (r == 0) begin
                do_reset();
            end else begin
                bit sh, jj, kk;
                sh = $urandom_range(0, 1);
                jj = $urandom_range(0, 1);
                kk = $urandom_range(0, 1);
                do_cycle(sh, jj, kk, 4'($urandom), sh ? "R1 R3 R4 R8" : "R2 R8");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule